// File: doc/BRIEF.md
# 40-bit Signed Multiply-Accumulate Unit

This block keeps a 40-bit signed running sum and adds signed products into it. Three product forms are offered. The first multiplies one 16-bit half of each 32-bit operand, and the half is picked separately for each operand. The second treats both operands as packed halfword pairs and adds both lane products in one step. The third is a full 32x32 multiply, of which only the low 40 bits of the 64-bit product reach the sum. The eight bits above a 32-bit word act as guard bits for long chains of 16-bit products. The sum wraps modulo 2^40 and never saturates.

A caller reads the sum at any time on a pair of 32-bit output words. It restores a saved sum through a pair of 32-bit input words. An operation is presented with `op_valid` for one clock. The halfword forms take effect at that edge. The 32x32 form takes two edges, and `busy` is high in between. Decoding of instructions and moving the sum to or from memory belong to the surrounding logic.

Top module: `mac40`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the sum to zero and drops `busy`.
- R2: `acc_lo` always shows sum bits 31:0. `acc_hi` shows sum bits 39:32 in its bits 7:0, and its bits 31:8 copy sum bit 39.
- R3: Operation code 1 multiplies one signed halfword of `opnd_a` by one signed halfword of `opnd_b`. `half_sel[1]` high picks bits 31:16 of `opnd_a`, and low picks bits 15:0. `half_sel[0]` does the same for `opnd_b`. The 32-bit product is sign-extended to 40 bits and added at the accepting edge, and `busy` stays low.
- R4: Operation code 2 adds two products at the accepting edge: `opnd_a[31:16]`×`opnd_b[31:16]` and `opnd_a[15:0]`×`opnd_b[15:0]`, each signed and sign-extended to 40 bits. `half_sel` has no effect, and `busy` stays low.
- R5: Operation code 3 adds bits 39:0 of the signed 64-bit product `opnd_a`×`opnd_b`. `busy` is high for exactly the one cycle after the accepting edge, and the new sum appears at the edge that ends it.
- R6: Every addition wraps modulo 2^40. A positive sum that passes 2^39−1 turns negative, and nothing saturates.
- R7: Operation code 4 replaces the sum with `{ld_hi[7:0], ld_lo}` at the accepting edge. Bits 31:8 of `ld_hi` are ignored.
- R8: While `busy` is high, any presented operation is ignored, and the sum afterwards holds only the 32x32 result.
- R9: With `op_valid` low, or with operation code 0, 5, 6 or 7, the sum does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Presents an operation this cycle |
| op_code | input | 3 | 0 none, 1 halfword product, 2 dual halfword, 3 word product, 4 load |
| half_sel | input | 2 | Halfword picks for code 1: bit 1 for `opnd_a`, bit 0 for `opnd_b`, high = upper half |
| opnd_a | input | 32 | Multiplier operand |
| opnd_b | input | 32 | Multiplicand operand |
| ld_lo | input | 32 | Load value for sum bits 31:0 |
| ld_hi | input | 32 | Bits 7:0 supply sum bits 39:32 on a load |
| busy | output | 1 | Word product in its second cycle |
| acc_lo | output | 32 | Sum bits 31:0 |
| acc_hi | output | 32 | Sum bits 39:32, sign-extended |

## Verification
The two activities that can share one cycle are the second half of a 32x32 product and a new operation presented while `busy` is high. The bench starts a word product with mixed-sign operands. In the busy cycle it presents a load with a distinctive value, and in a second run a halfword product. Each run passes only if `busy` drops after one cycle and the readout equals the previous sum plus the truncated 64-bit product, with no trace of the operation that was presented during `busy`.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
    localparam int ACC_W  = 40;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int GUARD_W = ACC_W - WORD_W;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_HALF = 3'd1,
        OP_DUAL = 3'd2,
        OP_WORD = 3'd3,
        OP_LOAD = 3'd4
    } mac_op_e;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic              busy;
        logic [ACC_W-1:0]  part;
        logic [WORD_W-1:0] a_keep;
        logic [HALF_W-1:0] bh_keep;
    } mac_state_t;
endpackage

// File: rtl/mac40_hmul.sv
// Signed halfword product, sign-extended to the sum width.
module mac40_hmul #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] y,
    output logic [ACC_W-1:0]  p
);
    localparam int PROD_W = 2 * HALF_W;

    logic signed [PROD_W-1:0] xe;
    logic signed [PROD_W-1:0] ye;
    logic signed [PROD_W-1:0] pr;

    always_comb begin
        xe = {{HALF_W{x[HALF_W-1]}}, x};
        ye = {{HALF_W{y[HALF_W-1]}}, y};
        pr = xe * ye;
        p  = {{(ACC_W-PROD_W){pr[PROD_W-1]}}, pr};
    end
endmodule

// File: rtl/mac40_wpart.sv
// One partial product of the word multiply, taken modulo 2^ACC_W.
// UPPER = 0: word x unsigned low half of the multiplicand.
// UPPER = 1: word x signed high half, weighted by 2^HALF_W.
module mac40_wpart #(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    parameter bit UPPER  = 1'b0
) (
    input  logic [WORD_W-1:0] a,
    input  logic [HALF_W-1:0] h,
    output logic [ACC_W-1:0]  p
);
    logic [ACC_W-1:0] ae;
    logic [ACC_W-1:0] he;
    logic [ACC_W-1:0] pr;

    assign ae = {{(ACC_W-WORD_W){a[WORD_W-1]}}, a};
    assign pr = ae * he;

    generate
        if (UPPER) begin : g_upper
            assign he = {{(ACC_W-HALF_W){h[HALF_W-1]}}, h};
            assign p  = {pr[ACC_W-HALF_W-1:0], {HALF_W{1'b0}}};
        end else begin : g_lower
            assign he = {{(ACC_W-HALF_W){1'b0}}, h};
            assign p  = pr;
        end
    endgenerate
endmodule

// File: rtl/mac40_rdfmt.sv
// Splits the sum into two readable words.
module mac40_rdfmt #(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]  acc,
    output logic [WORD_W-1:0] lo,
    output logic [WORD_W-1:0] hi
);
    localparam int GW = ACC_W - WORD_W;

    assign lo = acc[WORD_W-1:0];
    assign hi = {{(2*WORD_W-ACC_W){acc[ACC_W-1]}}, acc[ACC_W-1:WORD_W]};

    initial begin
        if (GW <= 0 || GW > WORD_W) $error("guard width out of range");
    end
endmodule

// File: rtl/mac40.sv
module mac40
    import mac40_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int WW = WORD_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [1:0]    half_sel,
    input  logic [WW-1:0] opnd_a,
    input  logic [WW-1:0] opnd_b,
    input  logic [WW-1:0] ld_lo,
    input  logic [WW-1:0] ld_hi,
    output logic          busy,
    output logic [WW-1:0] acc_lo,
    output logic [WW-1:0] acc_hi
);
    localparam int LANES = 2;

    mac_state_t st_d, st_q;
    mac_op_e    op_e;

    logic [HW-1:0] lx [LANES];
    logic [HW-1:0] ly [LANES];
    logic [AW-1:0] lp [LANES];
    logic [AW-1:0] lo_part;
    logic [AW-1:0] hi_part;

    assign op_e = mac_op_e'(op_code);

    // lane 0: selectable halves for the single form, low halves otherwise
    // lane 1: high halves, used by the dual form
    always_comb begin
        lx[0] = (op_e == OP_HALF && half_sel[1]) ? opnd_a[WW-1:HW] : opnd_a[HW-1:0];
        ly[0] = (op_e == OP_HALF && half_sel[0]) ? opnd_b[WW-1:HW] : opnd_b[HW-1:0];
        lx[1] = opnd_a[WW-1:HW];
        ly[1] = opnd_b[WW-1:HW];
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            mac40_hmul #(.HALF_W(HW), .ACC_W(AW)) u_hmul (
                .x(lx[g]),
                .y(ly[g]),
                .p(lp[g])
            );
        end
    endgenerate

    // first cycle of the word product: operand times low half of multiplicand
    mac40_wpart #(.WORD_W(WW), .HALF_W(HW), .ACC_W(AW), .UPPER(1'b0)) u_wlo (
        .a(opnd_a),
        .h(opnd_b[HW-1:0]),
        .p(lo_part)
    );

    // second cycle: held operand times held high half
    mac40_wpart #(.WORD_W(WW), .HALF_W(HW), .ACC_W(AW), .UPPER(1'b1)) u_whi (
        .a(st_q.a_keep),
        .h(st_q.bh_keep),
        .p(hi_part)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            // finishing the word product wins over anything presented now
            st_d.acc  = st_q.acc + st_q.part + hi_part;
            st_d.busy = 1'b0;
        end else if (op_valid) begin
            unique case (op_e)
                OP_HALF: st_d.acc = st_q.acc + lp[0];
                OP_DUAL: st_d.acc = st_q.acc + lp[0] + lp[1];
                OP_WORD: begin
                    st_d.part    = lo_part;
                    st_d.a_keep  = opnd_a;
                    st_d.bh_keep = opnd_b[WW-1:HW];
                    st_d.busy    = 1'b1;
                end
                OP_LOAD: st_d.acc = AW'({ld_hi, ld_lo});
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    mac40_rdfmt #(.WORD_W(WW), .ACC_W(AW)) u_rd (
        .acc(st_q.acc),
        .lo(acc_lo),
        .hi(acc_hi)
    );

    assign busy = st_q.busy;
endmodule

// File: rtl/mac40_chk.sv
module mac40_chk
    import mac40_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_code,
    input logic [31:0] ld_lo,
    input logic [31:0] ld_hi,
    input logic        busy,
    input logic [31:0] acc_lo,
    input logic [31:0] acc_hi
);
    logic take;
    assign take = op_valid && !busy;

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !busy)
        else $error("busy after reset");

    p_half_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (take && (op_code == OP_HALF || op_code == OP_DUAL)) |=> !busy)
        else $error("halfword form raised busy");

    p_word_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (take && op_code == OP_WORD) |=> busy)
        else $error("word product did not raise busy");

    p_busy_single_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy)
        else $error("busy longer than one cycle");

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (take && op_code == OP_LOAD) |=>
            (acc_lo == $past(ld_lo) && acc_hi[7:0] == $past(ld_hi[7:0])))
        else $error("load value wrong");

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !busy) |=> ($stable(acc_lo) && $stable(acc_hi)))
        else $error("sum moved while idle");
endmodule

bind mac40 mac40_chk u_chk (
    .clk(clk),
    .rst(rst),
    .op_valid(op_valid),
    .op_code(op_code),
    .ld_lo(ld_lo),
    .ld_hi(ld_hi),
    .busy(busy),
    .acc_lo(acc_lo),
    .acc_hi(acc_hi)
);

// File: tb/mac40_test.sv
`timescale 1ns/1ps
module mac40_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  half_sel = 2'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, ld_lo = '0, ld_hi = '0;
    logic        busy;
    logic [31:0] acc_lo, acc_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [39:0] model = '0;

    always #10 clk = ~clk;

    mac40 uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .half_sel(half_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .busy(busy),
        .acc_lo(acc_lo), .acc_hi(acc_hi)
    );

    function automatic logic [39:0] hprod(logic [15:0] x, logic [15:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[39:0];
    endfunction

    function automatic logic [39:0] wprod(logic [31:0] x, logic [31:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[39:0];
    endfunction

    task automatic chk1(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_sum(string req);
        chk1(req, acc_lo, model[31:0]);
        chk1(req, acc_hi, {{24{model[39]}}, model[39:32]});
    endtask

    // present one operation at a falling edge, hold it across one rising edge
    task automatic issue(logic [2:0] c, logic [1:0] s, logic [31:0] a, logic [31:0] b,
                         logic [31:0] l0, logic [31:0] l1);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; half_sel = s;
        opnd_a = a; opnd_b = b; ld_lo = l0; ld_hi = l1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk1("R1 busy", {31'd0, busy}, 32'd0);
        chk_sum("R1");
    endtask

    task automatic t_load;
        issue(3'd4, 2'd0, '0, '0, 32'h1234_5678, 32'hABCD_EF80);
        model = 40'h80_1234_5678;
        chk_sum("R7 R2 negative guard");
        issue(3'd4, 2'd0, '0, '0, 32'hDEAD_BEEF, 32'hFFFF_FF7F);
        model = 40'h7F_DEAD_BEEF;
        chk_sum("R7 R2 positive guard");
    endtask

    task automatic t_half;
        logic [31:0] a = 32'h8000_0003;
        logic [31:0] b = 32'h0005_FFFE;
        issue(3'd4, 2'd0, '0, '0, '0, '0);
        model = '0;
        for (int s = 0; s < 4; s++) begin
            issue(3'd1, 2'(s), a, b, '0, '0);
            model = model + hprod(s[1] ? a[31:16] : a[15:0], s[0] ? b[31:16] : b[15:0]);
            chk_sum($sformatf("R3 sel %0d", s));
            chk1("R3 busy", {31'd0, busy}, 32'd0);
        end
    endtask

    task automatic t_dual;
        logic [31:0] a = 32'h8000_7FFF;
        logic [31:0] b = 32'h8000_8001;
        issue(3'd2, 2'd3, a, b, '0, '0);
        model = model + hprod(a[31:16], b[31:16]) + hprod(a[15:0], b[15:0]);
        chk_sum("R4 dual");
        chk1("R4 busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_word(logic [31:0] a, logic [31:0] b, logic [2:0] intr, string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd3; opnd_a = a; opnd_b = b;
        @(negedge clk);
        chk1({"R5 busy high ", tag}, {31'd0, busy}, 32'd1);
        // R8: something else presented while busy
        op_code = intr; opnd_a = 32'h0000_7FFF; opnd_b = 32'h0000_7FFF;
        half_sel = 2'd0; ld_lo = 32'hCAFE_F00D; ld_hi = 32'h0000_0055;
        @(negedge clk);
        op_valid = 1'b0;
        model = model + wprod(a, b);
        chk1({"R5 busy low ", tag}, {31'd0, busy}, 32'd0);
        chk_sum({"R5 R8 ", tag});
    endtask

    task automatic t_wrap;
        issue(3'd4, 2'd0, '0, '0, 32'hFFFF_FFFF, 32'h0000_007F);
        issue(3'd1, 2'd0, 32'h1, 32'h1, '0, '0);
        model = 40'h80_0000_0000;
        chk_sum("R6 wrap up");
        issue(3'd4, 2'd0, '0, '0, 32'h0000_0000, 32'h0000_0080);
        issue(3'd1, 2'd0, 32'hFFFF, 32'h1, '0, '0);
        model = 40'h7F_FFFF_FFFF;
        chk_sum("R6 wrap down");
    endtask

    task automatic t_idle;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd4; ld_lo = 32'h1111_1111; ld_hi = 32'h22;
        opnd_a = 32'h7FFF_7FFF; opnd_b = 32'h7FFF_7FFF;
        @(negedge clk);
        chk_sum("R9 valid low");
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c > 4) begin
                issue(3'(c), 2'd3, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h3333_3333, 32'h44);
                chk_sum($sformatf("R9 code %0d", c));
            end
        end
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd3; opnd_a = 32'h1234_5678; opnd_b = 32'h1;
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        chk1("R1 busy cleared", {31'd0, busy}, 32'd0);
        chk_sum("R1 mid operation");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_half();
        t_dual();
        t_word(32'h8000_0000, 32'h7FFF_FFFF, 3'd4, "load intruder");
        t_word(32'hFFFF_FFFD, 32'h1234_5678, 3'd1, "half intruder");
        t_word(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd2, "dual intruder");
        t_wrap();
        t_idle();
        t_reset_again();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule